// File: doc/BRIEF.md
# Page Load and Program Sequencer

This block runs one page-programming pass for a word-organised one-time-programmable array. After a program command it opens a load window. During the window a host stores words into a 64-word page buffer with a write strobe. The address is taken when the strobe rises and the data when it falls. The first accepted word fixes the page, and any write aimed at a different page is dropped. Words may arrive in any order, and if an offset is written twice, the later data wins.

The load window closes by itself once the strobe has stayed low for a programmable number of clock cycles. The sequencer then walks the buffer in ascending offset order. For each word that was actually loaded, it issues one write to a simple array write port and then waits a programmable per-word program time. A fail-inject input from the array side aborts the pass and sets a sticky fail flag. While that flag is set, new program commands are refused until it is cleared.

Top module: `page_prog_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `load_o`, `busy_o`, `done_o`, `fail_o` and `arr_we_o` are all 0.
- R2: A `start_i` pulse in the idle state with `fail_o` low raises `load_o` after the next clock edge and empties the buffer, so words from an earlier pass are never written again.
- R3: A write takes its address from `wr_addr_i` in the first cycle `wr_strobe_i` is high and its data from `wr_data_i` in the first cycle the strobe is low again. Bits [5:0] are the word offset and bits [19:6] are the page.
- R4: Words may be loaded in any offset order. A second write to the same offset replaces the first.
- R5: The first write accepted in a window sets the page. A later write whose page bits differ is ignored and never reaches the array.
- R6: With the strobe low, `load_o` stays high for GAP_CYC clock edges counted from the first edge that sees the strobe low, then drops. While the strobe is high, the window never closes.
- R7: Programming issues exactly one single-cycle `arr_we_o` pulse for each loaded offset, in ascending offset order. `arr_addr_o` is {page, offset}. Consecutive pulses are at least PROG_CYC cycles apart.
- R8: `busy_o` is high only while programming and never together with `load_o`. `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls.
- R9: When `arr_fail_i` is high in a cycle where `arr_we_o` is high, `fail_o` is set, the remaining words are skipped, and `done_o` pulses.
- R10: `fail_o` stays set until `clr_fail_i` is asserted. While it is set, `start_i` does not open a load window.
- R11: A window that closes with no word loaded finishes with a `done_o` pulse and no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Program command accepted; opens a load window |
| wr_strobe_i | input | 1 | Word write strobe, active high |
| wr_addr_i | input | ADDR_W | Word address: page in the upper bits, offset in the low OFFS_W bits |
| wr_data_i | input | DATA_W | Word data, taken when the strobe falls |
| clr_fail_i | input | 1 | Clears the sticky fail flag |
| arr_fail_i | input | 1 | Array reports failure of the word being written |
| arr_we_o | output | 1 | Array write pulse |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| load_o | output | 1 | Load window open |
| busy_o | output | 1 | Programming in progress (not ready) |
| done_o | output | 1 | One-cycle pulse at the end of a programming pass |
| fail_o | output | 1 | Sticky program-fail flag |

## Verification
The bench builds the block with GAP_CYC = 12 and PROG_CYC = 3. The defaults stand for 100 µs and several microseconds of real time. With the short values, the exact closing edge of the load window can be checked against a hand count. A full 64-offset scan, an empty pass and an aborted pass each complete in a few hundred cycles. Because of this, every offset of the page can be compared after a mixed-order load that includes a duplicate and foreign-page writes.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_SCAN  = 3'd2,
    ST_ISSUE = 3'd3,
    ST_WAIT  = 3'd4
  } seq_state_t;

endpackage

// File: rtl/pgseq_edge.sv
module pgseq_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
  assign fall_o = ~level_i & level_q;

endmodule

// File: rtl/pgseq_gap_timer.sv
module pgseq_gap_timer #(
  parameter int GAP_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic hold_i,
  output logic expire_o
);

  localparam int CNT_W = $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && !hold_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || hold_i) cnt_q <= '0;
    else if (!expire_o)          cnt_q <= cnt_q + 1'b1;
  end

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST); // R6

endmodule

// File: rtl/pgseq_page_buf.sv
module pgseq_page_buf #(
  parameter int DATA_W = 16,
  parameter int OFFS_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear_i,
  input  logic                   we_i,
  input  logic [OFFS_W-1:0]      waddr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   re_i,
  input  logic [OFFS_W-1:0]      raddr_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [(1<<OFFS_W)-1:0] vld_o
);

  localparam int WORDS = 1 << OFFS_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  vld_q;

  // plain synchronous RAM: one write, one registered read
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) vld_q <= '0;
    else if (we_i)      vld_q[waddr_i] <= 1'b1;
  end

  assign vld_o = vld_q;

  AST_MASK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (vld_o == '0)); // R2

  AST_MASK_MARK: assert property (@(posedge clk) disable iff (rst)
    (we_i && !clear_i) |=> vld_o[$past(waddr_i)]); // R4

endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pgseq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int OFFS_W   = 6,
  parameter int GAP_CYC  = 5000,
  parameter int PROG_CYC = 350
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              wr_strobe_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_fail_i,
  input  logic              arr_fail_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);

  localparam int WORDS  = 1 << OFFS_W;
  localparam int PAGE_W = ADDR_W - OFFS_W;
  localparam int PT_W   = $clog2(PROG_CYC + 1);
  localparam logic [OFFS_W-1:0] LAST_IDX = '1;
  localparam logic [PT_W-1:0]   PT_LAST  = PT_W'(PROG_CYC - 1);

  seq_state_t        state_q;
  logic [PAGE_W-1:0] page_q;
  logic              page_set_q;
  logic              hit_q;
  logic [OFFS_W-1:0] off_q;
  logic [OFFS_W-1:0] idx_q;
  logic [PT_W-1:0]   pt_q;
  logic              arr_we_q;
  logic [ADDR_W-1:0] arr_addr_q;
  logic [DATA_W-1:0] arr_data_q;
  logic              done_q;
  logic              fail_q;

  logic              st_rise, st_fall, gap_exp;
  logic              in_load, start_ok, buf_we, buf_re;
  logic [DATA_W-1:0] buf_rd;
  logic [WORDS-1:0]  buf_vld;
  logic [PAGE_W-1:0] addr_page;
  logic [OFFS_W-1:0] addr_off;

  assign addr_page = wr_addr_i[ADDR_W-1:OFFS_W];
  assign addr_off  = wr_addr_i[OFFS_W-1:0];
  assign in_load   = (state_q == ST_LOAD);
  assign start_ok  = (state_q == ST_IDLE) && start_i && !fail_q;
  assign buf_we    = in_load && st_fall && hit_q;
  assign buf_re    = (state_q == ST_SCAN) && buf_vld[idx_q];

  pgseq_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (wr_strobe_i),
    .rise_o  (st_rise),
    .fall_o  (st_fall)
  );

  pgseq_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .run_i    (in_load),
    .hold_i   (wr_strobe_i),
    .expire_o (gap_exp)
  );

  pgseq_page_buf #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_ok),
    .we_i    (buf_we),
    .waddr_i (off_q),
    .wdata_i (wr_data_i),
    .re_i    (buf_re),
    .raddr_i (idx_q),
    .rdata_o (buf_rd),
    .vld_o   (buf_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      page_set_q <= 1'b0;
      hit_q      <= 1'b0;
      off_q      <= '0;
      idx_q      <= '0;
      pt_q       <= '0;
      arr_we_q   <= 1'b0;
      arr_addr_q <= '0;
      arr_data_q <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      arr_we_q <= 1'b0;
      done_q   <= 1'b0;
      if (clr_fail_i) fail_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          hit_q <= 1'b0;
          if (start_ok) begin
            state_q    <= ST_LOAD;
            page_set_q <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (st_rise) begin
            if (!page_set_q || addr_page == page_q) begin
              hit_q      <= 1'b1;
              off_q      <= addr_off;
              page_q     <= addr_page;
              page_set_q <= 1'b1;
            end else begin
              hit_q <= 1'b0;
            end
          end
          if (gap_exp) begin
            state_q <= ST_SCAN;
            idx_q   <= '0;
          end
        end
        ST_SCAN: begin
          if (buf_vld[idx_q]) begin
            state_q <= ST_ISSUE;
          end else if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_ISSUE: begin
          arr_we_q   <= 1'b1;
          arr_addr_q <= {page_q, idx_q};
          arr_data_q <= buf_rd;
          pt_q       <= '0;
          state_q    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (arr_we_q && arr_fail_i) begin
            fail_q  <= 1'b1;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (pt_q == PT_LAST) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_SCAN;
            end
          end else begin
            pt_q <= pt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arr_we_o   = arr_we_q;
  assign arr_addr_o = arr_addr_q;
  assign arr_data_o = arr_data_q;
  assign load_o     = in_load;
  assign busy_o     = (state_q == ST_SCAN) || (state_q == ST_ISSUE) || (state_q == ST_WAIT);
  assign done_o     = done_q;
  assign fail_o     = fail_q;

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_o, busy_o})); // R8

  AST_WE_IN_PROG: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> busy_o); // R7

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |=> !arr_we_o); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (rst)
    (load_o && wr_strobe_i) |=> load_o); // R6

  AST_FAIL_ABORT: assert property (@(posedge clk) disable iff (rst)
    (arr_we_o && arr_fail_i) |=> (fail_o && !busy_o && done_o)); // R9

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !clr_fail_i) |=> fail_o); // R10

  AST_BLOCK_START: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !load_o && !busy_o && start_i) |=> !load_o); // R10

endmodule

// File: tb/page_prog_seq_test.sv
module page_prog_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 12;
  localparam int PROG = 3;
  localparam int NV   = 8;

  // each entry: {page[13:0], offset[5:0], data[15:0]}
  localparam logic [35:0] VECS [NV] = '{
    {14'h0A5, 6'd40, 16'h1111},
    {14'h0A5, 6'd3,  16'h2222},
    {14'h0A5, 6'd63, 16'h3333},
    {14'h0B0, 6'd7,  16'hDEAD},
    {14'h0A5, 6'd0,  16'h4444},
    {14'h0A5, 6'd3,  16'h5555},
    {14'h0A5, 6'd17, 16'h6666},
    {14'h07F, 6'd17, 16'hBAD0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        wr_strobe_i = 1'b0;
  logic [19:0] wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        clr_fail_i = 1'b0;
  logic        arr_fail_i = 1'b0;
  logic        arr_we_o;
  logic [19:0] arr_addr_o;
  logic [15:0] arr_data_o;
  logic        load_o, busy_o, done_o, fail_o;

  int n_chk = 0;
  int n_fail = 0;

  page_prog_seq #(.GAP_CYC(GAP), .PROG_CYC(PROG)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .wr_strobe_i(wr_strobe_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .clr_fail_i(clr_fail_i),
    .arr_fail_i(arr_fail_i), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
    .arr_data_o(arr_data_o), .load_o(load_o), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // array-side monitor, sampled on the falling edge
  logic        mon_clr = 1'b0;
  logic [13:0] mon_page = '0;
  logic [63:0] cap_vld;
  logic [15:0] cap_dat [64];
  int wr_cnt, bad_page, bad_order, bad_space, cyc, last_cyc;
  logic [5:0] last_off;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      cap_vld <= '0; wr_cnt <= 0; bad_page <= 0; bad_order <= 0;
      bad_space <= 0; last_off <= '0; last_cyc <= 0;
    end else if (arr_we_o) begin
      cap_vld[arr_addr_o[5:0]] <= 1'b1;
      cap_dat[arr_addr_o[5:0]] <= arr_data_o;
      if (arr_addr_o[19:6] != mon_page) bad_page <= bad_page + 1;
      if (wr_cnt > 0 && arr_addr_o[5:0] <= last_off) bad_order <= bad_order + 1;
      if (wr_cnt > 0 && cyc - last_cyc < PROG) bad_space <= bad_space + 1;
      last_off <= arr_addr_o[5:0];
      last_cyc <= cyc;
      wr_cnt   <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input logic [13:0] pg);
    @(negedge clk); mon_clr = 1'b1; mon_page = pg;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  // address on a decoy value at the falling edge, data on a decoy at the rising edge
  task automatic put_word(input logic [13:0] pg, input logic [5:0] off, input logic [15:0] d);
    @(negedge clk); wr_addr_i = {pg, off}; wr_data_i = ~d; wr_strobe_i = 1'b1;
    @(negedge clk); wr_addr_i = ~{pg, off}; wr_data_i = d;
    @(negedge clk); wr_strobe_i = 1'b0;
    @(negedge clk); wr_data_i = 16'h0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 2000 && !seen; k++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
  endtask

  logic [63:0] exp_vld;
  logic [15:0] exp_dat [64];
  logic [13:0] exp_pg;
  logic        seen;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 load", load_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 fail", fail_o, 0);
    check("R1 we", arr_we_o, 0);

    // table-driven load: mixed order, duplicate, foreign pages
    exp_pg = VECS[0][35:22];
    exp_vld = '0;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][35:22] == exp_pg) begin
        exp_vld[VECS[i][21:16]] = 1'b1;
        exp_dat[VECS[i][21:16]] = VECS[i][15:0];
      end
    end
    clear_mon(exp_pg);
    pulse_start;
    check("R2 window open", load_o, 1);
    for (int i = 0; i < NV; i++) put_word(VECS[i][35:22], VECS[i][21:16], VECS[i][15:0]);
    wait_done(seen);
    check("R8 done pulse", seen, 1);
    @(negedge clk);
    check("R8 done one cycle", done_o, 0);
    check("R8 busy low", busy_o, 0);
    check("R7 write count", wr_cnt, $countones(exp_vld));
    check("R5 R7 page", bad_page, 0);
    check("R7 ascending", bad_order, 0);
    check("R7 spacing", bad_space, 0);
    check("R9 no fail", fail_o, 0);
    for (int o = 0; o < 64; o++) begin
      check("R3 R4 R5 offset written", cap_vld[o], exp_vld[o]);
      if (exp_vld[o]) check("R3 R4 data", cap_dat[o], exp_dat[o]);
    end

    // R6 gap timing and strobe hold
    clear_mon(14'h011);
    pulse_start;
    @(negedge clk); wr_addr_i = {14'h011, 6'd9}; wr_strobe_i = 1'b1;
    repeat (3*GAP) @(negedge clk);
    check("R6 held open", load_o, 1);
    wr_data_i = 16'hC0DE;
    @(negedge clk); wr_strobe_i = 1'b0;
    repeat (GAP-1) @(posedge clk);
    @(negedge clk);
    check("R6 still open", load_o, 1);
    @(negedge clk);
    check("R6 closed", load_o, 0);
    check("R8 busy after close", busy_o, 1);
    wait_done(seen);
    @(negedge clk);
    check("R2 only new word", wr_cnt, 1);
    check("R3 data", cap_dat[9], 16'hC0DE);

    // R11 empty window
    clear_mon(14'h000);
    pulse_start;
    wait_done(seen);
    @(negedge clk);
    check("R11 done", seen, 1);
    check("R11 no writes", wr_cnt, 0);

    // R9 fail aborts
    clear_mon(14'h022);
    pulse_start;
    put_word(14'h022, 6'd9, 16'hAAAA);
    put_word(14'h022, 6'd5, 16'hBBBB);
    arr_fail_i = 1'b1;
    wait_done(seen);
    arr_fail_i = 1'b0;
    @(negedge clk);
    check("R9 done", seen, 1);
    check("R9 fail set", fail_o, 1);
    check("R9 abort count", wr_cnt, 1);
    check("R9 first offset", cap_vld[5], 1);

    // R10 sticky fail blocks start
    pulse_start;
    check("R10 start refused", load_o, 0);
    repeat (5) @(negedge clk);
    check("R10 still set", fail_o, 1);
    @(negedge clk); clr_fail_i = 1'b1;
    @(negedge clk); clr_fail_i = 1'b0;
    check("R10 cleared", fail_o, 0);
    pulse_start;
    check("R10 start accepted", load_o, 1);
    wait_done(seen);
    check("R10 pass ends", seen, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

endmodule